// File: doc/BRIEF.md
# Multi-port ephemeral history register

This block stores a single word and offers K write ports and K read ports that all act in the same clock cycle, arranged in a fixed logical order. Read port 0 shows the stored word as it stood at the last clock edge. Each later read port shows the word as it would be after every lower-numbered write that is enabled this cycle. A chain of two-way multiplexers builds this view, so a port placed late in the order sees, in the same cycle, the data written by ports placed earlier.

At the clock edge the register takes the output of the final stage of the chain. That value is the data of the highest-numbered enabled write port. If no write port is enabled, the register keeps its word. Surrounding logic uses the ports to order operations inside one cycle: an operation wired to a higher-numbered port behaves as if it ran after the lower-numbered ones. The number of ports, the word width and the value loaded on reset are all parameters.

Top module: `ehr_multiport`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored word becomes `RESET_VALUE` whatever the write enables are, and read port 0 shows that value after the edge.
- R2: Read port 0 (bits `[WIDTH-1:0]` of `rd_data`) equals the stored word. Enabling or changing any write in the current cycle does not change it.
- R3: For each i from 0 to K-2, read port i+1 equals the data on write port i when `wr_en[i]` is 1. Otherwise it equals read port i. Port p occupies bits `[p*WIDTH +: WIDTH]` of both `wr_data` and `rd_data`.
- R4: At a rising edge without reset, when one or more write ports are enabled, the stored word becomes the data of the highest-indexed enabled port.
- R5: At a rising edge without reset, when no write port is enabled, the stored word keeps its value.
- R6: The read outputs depend combinationally on `wr_en` and `wr_data`. A change on those inputs is visible on the read ports in the same cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | PORTS | Enable for each write port, bit p for port p |
| wr_data | input | PORTS*WIDTH | Data for each write port, packed by port index |
| rd_data | output | PORTS*WIDTH | Value seen by each read port, packed by port index |

## Verification
The clocked properties assume that `rst` is high from time zero until the first edge. They assume that every write enable and write data bit is a known 0 or 1 whenever reset is low, because the checks compare the stored word with the values sampled in the previous cycle. The stimulus drives reset from the very start and changes inputs only at the falling edge. It sets every enable and data bit to a defined value in each cycle, including cycles where reset is asserted with writes enabled. It covers no writes, each single port alone, all ports together, and random mixes.

// File: rtl/ehr_pkg.sv
package ehr_pkg;

   // Lowest bit of lane idx in a vector packed lane by lane.
   function automatic int unsigned lane_lo(input int unsigned idx, input int unsigned w);
      return idx * w;
   endfunction

endpackage

// File: rtl/ehr_bypass_stage.sv
module ehr_bypass_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             take,
   input  logic [WIDTH-1:0] take_data,
   input  logic [WIDTH-1:0] pass_data,
   output logic [WIDTH-1:0] out_data
);

   always_comb begin
      if (take) out_data = take_data;
      else      out_data = pass_data;
   end

endmodule

// File: rtl/ehr_state_reg.sv
module ehr_state_reg #(
   parameter int unsigned           WIDTH       = 8,
   parameter logic [WIDTH-1:0]      RESET_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_VALUE;
      else     q <= d;
   end

   // R1: reset wins over any write
   p_reset_load_r1: assert property (@(posedge clk) rst |=> q == RESET_VALUE);

endmodule

// File: rtl/ehr_multiport.sv
module ehr_multiport #(
   parameter int unsigned      PORTS       = 4,
   parameter int unsigned      WIDTH       = 8,
   parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [PORTS-1:0]       wr_en,
   input  logic [PORTS*WIDTH-1:0] wr_data,
   output logic [PORTS*WIDTH-1:0] rd_data
);
   import ehr_pkg::*;

   localparam int unsigned STAGES = PORTS + 1;
   localparam int unsigned TOP_LO = PORTS*WIDTH - WIDTH;

   generate
      if (PORTS < 2) begin : g_bad_ports
         $error("ehr_multiport needs at least two ports");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ehr_multiport needs a non-zero width");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] state_q;

   assign chain[0] = state_q;

   for (genvar i = 0; i < PORTS; i++) begin : g_stage
      ehr_bypass_stage #(.WIDTH(WIDTH)) i_stage (
         .take      (wr_en[i]),
         .take_data (wr_data[lane_lo(i, WIDTH) +: WIDTH]),
         .pass_data (chain[i]),
         .out_data  (chain[i+1])
      );
      assign rd_data[lane_lo(i, WIDTH) +: WIDTH] = chain[i];
   end

   ehr_state_reg #(.WIDTH(WIDTH), .RESET_VALUE(RESET_VALUE)) i_state (
      .clk (clk),
      .rst (rst),
      .d   (chain[PORTS]),
      .q   (state_q)
   );

   // R3: each enabled write is seen by the next read port
   for (genvar j = 0; j + 1 < PORTS; j++) begin : g_chk
      p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
         wr_en[j] |-> rd_data[lane_lo(j+1, WIDTH) +: WIDTH] == wr_data[lane_lo(j, WIDTH) +: WIDTH]);
      p_pass_r3: assert property (@(posedge clk) disable iff (rst)
         !wr_en[j] |-> rd_data[lane_lo(j+1, WIDTH) +: WIDTH] == rd_data[lane_lo(j, WIDTH) +: WIDTH]);
   end

   // R4: the top write port always wins
   p_top_wins_r4: assert property (@(posedge clk) disable iff (rst)
      wr_en[PORTS-1] |=> rd_data[WIDTH-1:0] == $past(wr_data[TOP_LO +: WIDTH]));

   // R5: no write leaves port 0 unchanged
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      wr_en == '0 |=> $stable(rd_data[WIDTH-1:0]));

   // R2: port 0 only moves at an edge, to the last chain stage
   p_port0_commit_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> rd_data[WIDTH-1:0] == $past(chain[PORTS]));

endmodule

// File: tb/test_ehr_multiport.sv
module test_ehr_multiport;
   localparam int unsigned PORTS = 4;
   localparam int unsigned WIDTH = 8;
   localparam logic [WIDTH-1:0] RV = 8'hA5;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic [PORTS-1:0]       wr_en = '0;
   logic [PORTS*WIDTH-1:0] wr_data = '0;
   logic [PORTS*WIDTH-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   logic [WIDTH-1:0] model;

   always #5 clk = ~clk;

   ehr_multiport #(.PORTS(PORTS), .WIDTH(WIDTH), .RESET_VALUE(RV)) i_ehr_multiport (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected view of read port p, from the model word and the current inputs.
   function automatic logic [WIDTH-1:0] view(input int p);
      logic [WIDTH-1:0] v = model;
      for (int k = 0; k < p; k++)
         if (wr_en[k]) v = wr_data[k*WIDTH +: WIDTH];
      return v;
   endfunction

   task automatic compare_all();
      check("R2 port0", rd_data[WIDTH-1:0], view(0));
      for (int p = 1; p < PORTS; p++)
         check("R3 bypass", rd_data[p*WIDTH +: WIDTH], view(p));
   endtask

   // One cycle: drive at falling edge, compare, then advance the model.
   task automatic step(input logic [PORTS-1:0] en, input logic [PORTS*WIDTH-1:0] d, input logic r);
      logic any;
      @(negedge clk);
      wr_en = en; wr_data = d; rst = r;
      #1;
      compare_all();
      any = |en;
      @(posedge clk);
      #1;
      if (r) begin
         model = RV;
         check("R1 reset", rd_data[WIDTH-1:0], RV);
      end else begin
         model = view(PORTS);
         if (any) check("R4 commit", rd_data[WIDTH-1:0], model);
         else     check("R5 hold",   rd_data[WIDTH-1:0], model);
      end
   endtask

   initial begin : watchdog
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      model = RV;
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset value", rd_data[WIDTH-1:0], RV);
      step('0, '0, 1'b0);
      // each single port alone
      for (int p = 0; p < PORTS; p++) begin
         logic [PORTS*WIDTH-1:0] d = '0;
         d[p*WIDTH +: WIDTH] = 8'h10 + 8'(p);
         step(PORTS'(1) << p, d, 1'b0);
      end
      // all ports together: top wins
      step('1, {8'h44, 8'h33, 8'h22, 8'h11}, 1'b0);
      step('0, {8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
      step(4'b0101, {8'hDE, 8'h77, 8'hAD, 8'h66}, 1'b0);
      // reset while writing
      step('1, {8'h01, 8'h02, 8'h03, 8'h04}, 1'b1);
      step('0, '0, 1'b0);
      // same-cycle visibility without an edge
      @(negedge clk);
      wr_en = 4'b0001; wr_data = {8'h00, 8'h00, 8'h00, 8'h5C};
      #1;
      check("R6 same cycle", rd_data[3*WIDTH +: WIDTH], 8'h5C);
      wr_data[7:0] = 8'hC5;
      #1;
      check("R6 same cycle", rd_data[3*WIDTH +: WIDTH], 8'hC5);
      check("R2 port0 unchanged", rd_data[WIDTH-1:0], model);
      wr_en = '0;
      #1;
      check("R6 same cycle", rd_data[3*WIDTH +: WIDTH], model);
      // random mixes
      for (int n = 0; n < 300; n++)
         step(PORTS'($urandom), {$urandom}, ($urandom % 40) == 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule